// File: doc/BRIEF.md
# Display Host Write Register File

This block is the processor-facing register file of an eight-digit alphanumeric display controller. A host drives an 8-bit data byte, a 4-bit address, an active-low select, an active-low write strobe and a plane-select line. Each write goes to one of three stores. The first is a control word. The second is an eight-entry glyph memory; each entry holds a 7-bit character code and a font-page bit. The third is an eight-entry single-bit flash-attribute memory.

The host pins are asynchronous to the internal clock, so the block first brings them into that clock domain. It then accepts one write for each assertion of the qualified strobe. The refresh logic reads the stores through a digit-indexed glyph port, a flash vector and the control word.

A control write with the clear bit set fills every digit with a blank. It leaves the rest of the control byte in place and does not touch the flash attributes.

Top module: `disp_host_regs`

## Requirements
- R1: Nothing is stored unless `cs_n` and `wr_n` are both sampled low. A strobe with either line high leaves every store unchanged.
- R2: With `fsel`=1 and `addr`=4'b0000, the control word takes `din`, but bit 7 always reads back as 0.
- R3: With `fsel`=1 and `addr[3]`=1, digit `addr[2:0]` is written: `din[6:0]` becomes its code and `din[7]` its font page. Digit 0 is the leftmost digit.
- R4: With `fsel`=0, the flash bit of digit `addr[2:0]` takes `din[0]`. The values of `addr[3]` and `din[7:1]` have no effect.
- R5: With `fsel`=1, `addr[3]`=0 and `addr[2:0]` not 000, the write is a no-operation.
- R6: A glyph or flash write changes only its own entry. The control word and the other store are left unchanged.
- R7: After reset the control word is 8'h00, which includes brightness field `[2:0]`=0, meaning full brightness. Every flash bit is 0, and every digit holds the blank glyph: code 7'h20, page 0.
- R8: A control write with `din[7]`=1 stores the other seven bits and blanks all eight digits on the same clock edge. The flash bits are untouched.
- R9: A write is committed on the third rising clock edge after the strobe is first sampled asserted. It is committed once, however long the strobe is held.
- R10: A strobe that is still asserted when reset is released is not committed. The next fresh strobe is committed normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cs_n | input | 1 | Active-low select from the host |
| wr_n | input | 1 | Active-low write strobe from the host |
| fsel | input | 1 | Plane select: 1 selects control/glyph writes, 0 selects flash writes |
| addr | input | 4 | Digit index in bits [2:0]; bit 3 picks glyph or control |
| din | input | 8 | Write data byte |
| rd_idx | input | 3 | Digit that the glyph read port shows |
| ctrl_word | output | 8 | Stored control word |
| rd_code | output | 7 | Character code of digit `rd_idx` |
| rd_page | output | 1 | Font page of digit `rd_idx` |
| flash_vec | output | 8 | Flash attribute bits, bit n for digit n |

## Verification
Two events can fall on the same clock edge: the release of power-up reset and a pending host strobe. The bench asserts reset while a glyph write is held on the bus and releases reset with the strobe still low. It then checks that the digit stays blank through the rest of that strobe and after it ends, and that a fresh strobe to the same digit lands. A second coincidence is the blanking and the control load caused by one clear write. The bench checks the new control byte, all eight digits and the flash bits after that single commit.

// File: rtl/disp_host_pkg.sv
package disp_host_pkg;

    parameter int CODE_W  = 7;
    parameter int CLR_BIT = 7;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_CTRL,
        WR_CHAR,
        WR_FLASH
    } wr_kind_e;

    typedef struct packed {
        logic              page;
        logic [CODE_W-1:0] code;
    } glyph_t;

    localparam glyph_t BLANK_GLYPH = '{page: 1'b0, code: 7'h20};

endpackage

// File: rtl/disp_bus_sync.sv
module disp_bus_sync #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              fsel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_pulse,
    output logic              fsel_s,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DATA_W-1:0] din_s
);

    localparam int BW = 2 + ADDR_W + DATA_W;
    // Strobe stages reset as "active" so a strobe held through reset gives no edge.
    localparam logic [BW-1:0] RST_VAL = {1'b1, {(BW-1){1'b0}}};

    logic [BW-1:0] pipe_d [STAGES];
    logic [BW-1:0] pipe_q [STAGES];
    logic          prev_d, prev_q;

    always_comb begin
        pipe_d[0] = {~cs_n & ~wr_n, fsel, addr, din};
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
        prev_d = pipe_q[STAGES-1][BW-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= RST_VAL;
            end
            prev_q <= 1'b1;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
            prev_q <= prev_d;
        end
    end

    assign wr_pulse = pipe_q[STAGES-1][BW-1] & ~prev_q;
    assign fsel_s   = pipe_q[STAGES-1][BW-2];
    assign addr_s   = pipe_q[STAGES-1][DATA_W +: ADDR_W];
    assign din_s    = pipe_q[STAGES-1][DATA_W-1:0];

endmodule

// File: rtl/disp_wr_decode.sv
module disp_wr_decode
    import disp_host_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             fsel,
    input  logic [IDX_W:0]   addr,
    output wr_kind_e         kind,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = addr[IDX_W-1:0];
        if (!fsel) begin
            kind = WR_FLASH;
        end else if (addr[IDX_W]) begin
            kind = WR_CHAR;
        end else if (idx == '0) begin
            kind = WR_CTRL;
        end else begin
            kind = WR_NONE;
        end
    end

endmodule

// File: rtl/disp_host_regs.sv
module disp_host_regs
    import disp_host_pkg::*;
#(
    parameter int DIGITS      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(DIGITS),
    localparam int ADDR_W     = IDX_W + 1,
    localparam int DATA_W     = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              fsel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [CODE_W-1:0] rd_code,
    output logic              rd_page,
    output logic [DIGITS-1:0] flash_vec
);

    typedef struct packed {
        logic [DATA_W-1:0]       ctrl;
        glyph_t [DIGITS-1:0]     chars;
        logic [DIGITS-1:0]       flash;
    } regs_t;

    logic              wr_pulse;
    logic              fsel_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    wr_kind_e          kind;
    logic [IDX_W-1:0]  idx;
    regs_t             st_d, st_q;

    disp_bus_sync #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .fsel     (fsel),
        .addr     (addr),
        .din      (din),
        .wr_pulse (wr_pulse),
        .fsel_s   (fsel_s),
        .addr_s   (addr_s),
        .din_s    (din_s)
    );

    disp_wr_decode #(
        .IDX_W (IDX_W)
    ) i_decode (
        .fsel (fsel_s),
        .addr (addr_s),
        .kind (kind),
        .idx  (idx)
    );

    always_comb begin
        st_d = st_q;
        if (wr_pulse) begin
            unique case (kind)
                WR_CTRL: begin
                    st_d.ctrl          = din_s;
                    st_d.ctrl[CLR_BIT] = 1'b0;
                    if (din_s[CLR_BIT]) begin
                        for (int i = 0; i < DIGITS; i++) begin
                            st_d.chars[i] = BLANK_GLYPH;
                        end
                    end
                end
                WR_CHAR: begin
                    st_d.chars[idx].page = din_s[DATA_W-1];
                    st_d.chars[idx].code = din_s[CODE_W-1:0];
                end
                WR_FLASH: begin
                    st_d.flash[idx] = din_s[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl  <= '0;
            st_q.flash <= '0;
            for (int i = 0; i < DIGITS; i++) begin
                st_q.chars[i] <= BLANK_GLYPH;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_word = st_q.ctrl;
    assign flash_vec = st_q.flash;
    assign rd_code   = st_q.chars[rd_idx].code;
    assign rd_page   = st_q.chars[rd_idx].page;

endmodule

// File: rtl/disp_host_chk.sv
module disp_host_chk
    import disp_host_pkg::*;
#(
    parameter int DIGITS = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DIGITS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_pulse,
    input wr_kind_e          kind,
    input logic [IDX_W-1:0]  idx,
    input logic [DATA_W-1:0] din_s,
    input logic [DATA_W-1:0] ctrl_word,
    input logic [DIGITS-1:0] flash_vec
);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> ($stable(ctrl_word) && $stable(flash_vec)));

    // R4
    flash_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && kind == WR_FLASH) |=> (flash_vec[$past(idx)] == $past(din_s[0])));

    // R6
    char_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && kind == WR_CHAR) |=> ($stable(ctrl_word) && $stable(flash_vec)));

    // R8
    clear_keeps_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && kind == WR_CTRL) |=> ($stable(flash_vec) && !ctrl_word[CLR_BIT]));

    // R9
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R7
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (ctrl_word == '0 && flash_vec == '0);
        end
    end

endmodule

bind disp_host_regs disp_host_chk #(
    .DIGITS (DIGITS),
    .DATA_W (DATA_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_pulse  (wr_pulse),
    .kind      (kind),
    .idx       (idx),
    .din_s     (din_s),
    .ctrl_word (ctrl_word),
    .flash_vec (flash_vec)
);

// File: tb/test_disp_host_regs.sv
module test_disp_host_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       fsel = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] din = '0;
    logic [2:0] rd_idx = '0;
    logic [7:0] ctrl_word;
    logic [6:0] rd_code;
    logic       rd_page;
    logic [7:0] flash_vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    disp_host_regs i_disp_host_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .fsel      (fsel),
        .addr      (addr),
        .din       (din),
        .rd_idx    (rd_idx),
        .ctrl_word (ctrl_word),
        .rd_code   (rd_code),
        .rd_page   (rd_page),
        .flash_vec (flash_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic glyph(input int d, output logic [7:0] g);
        rd_idx = d[2:0];
        #1;
        g = {rd_page, rd_code};
    endtask

    task automatic chk_glyphs(input string req, input logic [7:0] exp [8]);
        logic [7:0] g;
        for (int d = 0; d < 8; d++) begin
            glyph(d, g);
            chk(req, {24'h0, g}, {24'h0, exp[d]});
        end
    endtask

    task automatic bus_write(input logic f, input logic [3:0] a, input logic [7:0] d,
                             input logic cs, input logic wr);
        @(negedge clk);
        fsel = f; addr = a; din = d; cs_n = cs; wr_n = wr;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    logic [7:0] exp_g [8];
    logic [7:0] exp_f;

    task automatic t_reset();
        do_reset();
        for (int d = 0; d < 8; d++) exp_g[d] = 8'h20;
        exp_f = '0;
        chk("R7 ctrl", {24'h0, ctrl_word}, 32'h0);
        chk("R7 flash", {24'h0, flash_vec}, 32'h0);
        chk_glyphs("R7 glyph", exp_g);
    endtask

    task automatic t_glyph();
        for (int d = 0; d < 8; d++) begin
            exp_g[d] = {d[0], 7'h41 + 7'(d)};
            bus_write(1'b1, {1'b1, 3'(d)}, exp_g[d], 1'b0, 1'b0);
        end
        chk_glyphs("R3 glyph", exp_g);
        chk("R6 ctrl kept", {24'h0, ctrl_word}, 32'h0);
        chk("R6 flash kept", {24'h0, flash_vec}, {24'h0, exp_f});
    endtask

    task automatic t_flash();
        bus_write(1'b0, 4'b1010, 8'hFF, 1'b0, 1'b0);
        exp_f[2] = 1'b1;
        bus_write(1'b0, 4'b0101, 8'h01, 1'b0, 1'b0);
        exp_f[5] = 1'b1;
        chk("R4 flash set", {24'h0, flash_vec}, {24'h0, exp_f});
        bus_write(1'b0, 4'b0010, 8'hFE, 1'b0, 1'b0);
        exp_f[2] = 1'b0;
        chk("R4 flash clr", {24'h0, flash_vec}, {24'h0, exp_f});
        chk_glyphs("R6 glyph kept", exp_g);
    endtask

    task automatic t_ctrl();
        bus_write(1'b1, 4'b0000, 8'h05, 1'b0, 1'b0);
        chk("R2 ctrl", {24'h0, ctrl_word}, 32'h05);
        chk_glyphs("R2 glyph kept", exp_g);
    endtask

    task automatic t_ignored();
        bus_write(1'b1, 4'b0011, 8'hAA, 1'b0, 1'b0);
        chk("R5 ctrl", {24'h0, ctrl_word}, 32'h05);
        chk_glyphs("R5 glyph", exp_g);
        chk("R5 flash", {24'h0, flash_vec}, {24'h0, exp_f});
        bus_write(1'b1, 4'b1000, 8'h33, 1'b1, 1'b0);
        bus_write(1'b0, 4'b0000, 8'h01, 1'b0, 1'b1);
        chk_glyphs("R1 glyph", exp_g);
        chk("R1 flash", {24'h0, flash_vec}, {24'h0, exp_f});
        chk("R1 ctrl", {24'h0, ctrl_word}, 32'h05);
    endtask

    task automatic t_latency();
        @(negedge clk);
        fsel = 1'b1; addr = 4'b0000; din = 8'h06; cs_n = 1'b0; wr_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 chk("R9 before", {24'h0, ctrl_word}, 32'h05);
        @(posedge clk);
        #1 chk("R9 at edge 3", {24'h0, ctrl_word}, 32'h06);
        @(negedge clk);
        din = 8'h04;
        repeat (10) @(negedge clk);
        chk("R9 once", {24'h0, ctrl_word}, 32'h06);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_clear();
        bus_write(1'b1, 4'b0000, 8'h83, 1'b0, 1'b0);
        for (int d = 0; d < 8; d++) exp_g[d] = 8'h20;
        chk("R8 ctrl", {24'h0, ctrl_word}, 32'h03);
        chk_glyphs("R8 blank", exp_g);
        chk("R8 flash", {24'h0, flash_vec}, {24'h0, exp_f});
    endtask

    task automatic t_reset_overlap();
        logic [7:0] g;
        @(negedge clk);
        fsel = 1'b1; addr = 4'b1001; din = 8'h5A; cs_n = 1'b0; wr_n = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        glyph(1, g);
        chk("R10 held", {24'h0, g}, 32'h20);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (4) @(negedge clk);
        glyph(1, g);
        chk("R10 after", {24'h0, g}, 32'h20);
        bus_write(1'b1, 4'b1001, 8'h5A, 1'b0, 1'b0);
        glyph(1, g);
        chk("R10 fresh", {24'h0, g}, 32'h5A);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_glyph();
        t_flash();
        t_ctrl();
        t_ignored();
        t_latency();
        t_clear();
        t_reset_overlap();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule